// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block drives the transmit side of a packet DMA engine. It walks a ring of four-word descriptors in main memory, starting at a programmed base address. For each descriptor it reads the status word. If the ownership flag shows that hardware holds the descriptor, it reads the control word and the buffer pointer. It then fetches the buffer one 32-bit word at a time and streams the bytes, least significant byte first, to a byte-wide interface on the MAC side. At the end it writes the status word back with ownership handed to software and a done flag set.

When it reaches a descriptor that software still holds, the engine parks on that descriptor and issues no further memory traffic. Software fills descriptors and then strobes a poll-demand input, which makes the engine read the same status word again. A wrap flag in the control word sends the walk back to the base address. A configuration bit selects the spacing between descriptors: either packed, or with four spare words after each one.

Top module: `txring_fetcher`

## Requirements
- R1: While reset is held, `mem_req`, `tx_valid` and `tx_done` are all low.
- R2: After `cfg_enable` rises, the first memory access is a read of the status word at `cfg_base`.
- R3: A descriptor whose status bit 31 is 1 is hardware-owned. The engine reads the control word at offset +1, whose bits 10:0 give the byte length, and the buffer word address at offset +2. It then emits exactly that many bytes from consecutive buffer words, taking byte 0 from bits 7:0. `tx_last` is high on the final byte only.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values, and the byte is not lost.
- R5: After a frame, the engine writes 32'h4000_0000 to the status word (bit 31 clear, done bit 30 set). `tx_done` then pulses for exactly one cycle, in the cycle after that write is acknowledged.
- R6: Without the control-word wrap bit, the next descriptor lies 4 words further on when `cfg_wide_gap` is 0, and 8 words further on when it is 1. Words in the gap are never touched.
- R7: A descriptor with control bit 21 set is followed by the descriptor at `cfg_base`.
- R8: On a status word with bit 31 clear, the engine suspends and makes no further memory requests. Each `poll_wr` pulse re-reads that same status word, and the engine proceeds only if the bit is now set.
- R9: A memory request keeps `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack` is high.
- R10: A hardware-owned descriptor with length 0 emits no bytes but is still written back and counted by `tx_done`.
- R11: Dropping `cfg_enable` stops all memory and stream activity within one cycle. Re-enabling restarts the walk at the current `cfg_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Engine run enable |
| cfg_wide_gap | input | 1 | 1: descriptor stride of 8 words, 0: stride of 4 |
| cfg_base | input | AW | Word address of the first descriptor of the ring |
| poll_wr | input | 1 | Poll-demand strobe that restarts a suspended engine |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Frame byte available |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC side accepts the byte |
| tx_done | output | 1 | One-cycle pulse per completed descriptor |

## Verification
The hardest situation to reach is the suspended engine. Getting there needs a full lap of the ring, so that the wrap lands on a descriptor the engine has already returned to software. The bench lets the first lap run to that point and checks that memory stays silent. It then strobes a poll while the descriptor is still software-owned, which must cause exactly one re-read. Finally it hands the descriptor back as a zero-length frame and polls again. All of this runs with random stream back-pressure and address-dependent memory latency.

// File: rtl/txring_fetcher.sv
module txring_fetcher #(
  parameter int AW      = 16,
  parameter int LW      = 11,
  parameter int EOR_BIT = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_wide_gap,
  input  logic [AW-1:0] cfg_base,
  input  logic          poll_wr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          tx_done
);
  localparam logic [31:0]   DONE_STATUS = 32'h4000_0000;
  localparam logic [AW-1:0] STEP_NARROW = AW'(4);
  localparam logic [AW-1:0] STEP_WIDE   = AW'(8);
  localparam logic [LW-1:0] ONE_LEFT    = LW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_STAT, S_CTL, S_BUF, S_WORD, S_SEND, S_WB, S_SUSP
  } state_t;

  state_t        st;
  logic [AW-1:0] dptr, bptr;
  logic [LW-1:0] left;
  logic [1:0]    bsel;
  logic [31:0]   word;
  logic          wrap;

  assign mem_req   = st inside {S_STAT, S_CTL, S_BUF, S_WORD, S_WB};
  assign mem_we    = (st == S_WB);
  assign mem_wdata = DONE_STATUS;
  assign tx_valid  = (st == S_SEND);
  assign tx_data   = word[8*bsel +: 8];
  assign tx_last   = tx_valid && (left == ONE_LEFT);

  always_comb begin
    case (st)
      S_CTL:   mem_addr = dptr + AW'(1);
      S_BUF:   mem_addr = dptr + AW'(2);
      S_WORD:  mem_addr = bptr;
      default: mem_addr = dptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dptr    <= '0;
      bptr    <= '0;
      left    <= '0;
      bsel    <= '0;
      word    <= '0;
      wrap    <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (!cfg_enable) begin
        st   <= S_IDLE;
        dptr <= cfg_base;
      end else begin
        case (st)
          S_IDLE: begin
            dptr <= cfg_base;
            st   <= S_STAT;
          end
          S_STAT: if (mem_ack) st <= mem_rdata[31] ? S_CTL : S_SUSP;
          S_SUSP: if (poll_wr) st <= S_STAT;
          S_CTL: if (mem_ack) begin
            left <= mem_rdata[LW-1:0];
            wrap <= mem_rdata[EOR_BIT];
            st   <= (mem_rdata[LW-1:0] == '0) ? S_WB : S_BUF;
          end
          S_BUF: if (mem_ack) begin
            bptr <= mem_rdata[AW-1:0];
            st   <= S_WORD;
          end
          S_WORD: if (mem_ack) begin
            word <= mem_rdata;
            bsel <= '0;
            st   <= S_SEND;
          end
          S_SEND: if (tx_ready) begin
            left <= left - ONE_LEFT;
            bsel <= bsel + 2'd1;
            if (left == ONE_LEFT) st <= S_WB;
            else if (bsel == 2'd3) begin
              bptr <= bptr + AW'(1);
              st   <= S_WORD;
            end
          end
          S_WB: if (mem_ack) begin
            tx_done <= 1'b1;
            dptr    <= wrap ? cfg_base : dptr + (cfg_wide_gap ? STEP_WIDE : STEP_NARROW);
            st      <= S_STAT;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/txring_fetcher_chk.sv
module txring_fetcher_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_enable,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          tx_ready,
  input logic          tx_done
);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && cfg_enable) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r4_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && cfg_enable) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  a_r5_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && cfg_enable) |=> tx_done);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  a_r3_stream_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !mem_req);

  a_r11_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!mem_req && !tx_valid));
endmodule

bind txring_fetcher txring_fetcher_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
  .tx_done(tx_done)
);

// File: tb/txring_fetcher_tb.sv
module txring_fetcher_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_wide_gap = 1'b0, poll_wr = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_last, tx_ready = 1'b0, tx_done;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  txring_fetcher #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wide_gap(cfg_wide_gap),
    .cfg_base(cfg_base), .poll_wr(poll_wr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_done(tx_done)
  );

  logic [31:0] mem [0:1023];
  logic [8:0]  exp_b [$];
  int          exp_w [$];
  int n_cmp = 0, n_bad = 0;
  int done_cnt = 0, rd_cnt = 0, last_rd = -1, wcnt = 0;
  logic [7:0] lf = 8'h5a;
  logic prev_pend = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic add_desc(input int a, input bit own, input bit eor, input int len,
                          input int bufa, input int seed);
    mem[a]   = own ? 32'h8000_0000 : 32'h0;
    mem[a+1] = (32'(eor) << 21) | 32'(len);
    mem[a+2] = 32'(bufa);
    mem[a+3] = 32'h0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 7) & 255);
      mem[bufa + i/4][8*(i%4) +: 8] = b;
      if (own) exp_b.push_back({(i == len - 1), b});
    end
    if (own) exp_w.push_back(a);
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll_wr = 1'b1;
    @(negedge clk); poll_wr = 1'b0;
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(posedge clk);
  endtask

  // monitor, stream sink and memory model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (tx_done) done_cnt++;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        tx_ready = lf[0] | lf[2];
        if (tx_valid && tx_ready) begin
          if (exp_b.size() == 0) chk(0, "R3", "unexpected byte", tx_data, 0);
          else begin
            logic [8:0] e;
            e = exp_b.pop_front();
            chk(tx_data == e[7:0], "R3 R4", "byte", tx_data, e[7:0]);
            chk(tx_last == e[8], "R3", "last flag", tx_last, e[8]);
          end
        end
        if (prev_pend && mem_req)
          chk(mem_addr == prev_addr, "R9", "held address", mem_addr, prev_addr);
        mem_ack = 1'b0;
        if (mem_req) begin
          if (wcnt >= int'(mem_addr[1:0])) begin
            mem_ack = 1'b1;
            wcnt = 0;
            if (mem_we) begin
              if (exp_w.size() == 0) chk(0, "R5", "unexpected write", mem_addr, 0);
              else begin
                int ea;
                ea = exp_w.pop_front();
                chk(int'(mem_addr) == ea, "R5", "writeback address", mem_addr, ea);
              end
              chk(mem_wdata == 32'h4000_0000, "R5", "writeback data", mem_wdata, 32'h4000_0000);
              mem[mem_addr[9:0]] = mem_wdata;
            end else begin
              mem_rdata = mem[mem_addr[9:0]];
              rd_cnt++;
              last_rd = int'(mem_addr);
            end
          end else wcnt++;
        end
        prev_pend = mem_req && !mem_ack;
        prev_addr = mem_addr;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R8", "watchdog expired", done_cnt, 0);
    summary();
    $finish;
  end

  initial begin
    int r0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    cfg_base = AW'(16);
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
    chk(tx_valid == 1'b0, "R1", "tx_valid in reset", tx_valid, 0);
    chk(tx_done == 1'b0, "R1", "tx_done in reset", tx_done, 0);
    rst_n = 1'b1;

    add_desc(16, 1, 0, 5, 100, 1);
    add_desc(20, 1, 0, 1, 110, 50);
    add_desc(24, 1, 1, 9, 120, 90);
    @(negedge clk); cfg_enable = 1'b1;
    @(negedge clk);
    while (!mem_req) @(negedge clk);
    chk(mem_addr == AW'(16) && !mem_we, "R2", "first access", mem_addr, 16);
    wait_done(3);
    repeat (30) @(negedge clk);
    chk(exp_b.size() == 0, "R3", "bytes left", exp_b.size(), 0);
    chk(exp_w.size() == 0, "R6", "writes left", exp_w.size(), 0);
    chk(last_rd == 16, "R7", "wrap read address", last_rd, 16);
    chk(done_cnt == 3, "R5", "done pulses", done_cnt, 3);
    r0 = rd_cnt;
    repeat (40) @(negedge clk);
    chk(rd_cnt == r0, "R8", "reads while suspended", rd_cnt, r0);

    pulse_poll();
    repeat (30) @(negedge clk);
    chk(rd_cnt == r0 + 1, "R8", "reads after poll on sw-owned", rd_cnt, r0 + 1);
    chk(last_rd == 16, "R8", "poll re-read address", last_rd, 16);
    chk(done_cnt == 3, "R8", "no progress when sw-owned", done_cnt, 3);

    add_desc(16, 1, 0, 0, 0, 0);
    pulse_poll();
    wait_done(4);
    repeat (30) @(negedge clk);
    chk(exp_w.size() == 0, "R10", "zero-length writeback", exp_w.size(), 0);
    chk(exp_b.size() == 0, "R10", "zero-length bytes", exp_b.size(), 0);
    chk(last_rd == 20, "R6", "narrow stride next status", last_rd, 20);

    @(negedge clk); cfg_enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_req == 1'b0 && tx_valid == 1'b0, "R11", "quiet when disabled", mem_req, 0);
    cfg_base = AW'(200);
    cfg_wide_gap = 1'b1;
    add_desc(200, 1, 0, 4, 300, 3);
    mem[204] = 32'h8000_000F;
    add_desc(208, 1, 1, 13, 320, 17);
    @(negedge clk); cfg_enable = 1'b1;
    wait_done(6);
    repeat (30) @(negedge clk);
    chk(exp_b.size() == 0, "R11", "bytes left after restart", exp_b.size(), 0);
    chk(exp_w.size() == 0, "R6", "wide writes left", exp_w.size(), 0);
    chk(mem[204] == 32'h8000_000F, "R6", "gap word untouched", mem[204], 32'h8000_000F);
    chk(last_rd == 200, "R7", "wrap to new base", last_rd, 200);
    chk(done_cnt == 6, "R5", "total done pulses", done_cnt, 6);

    summary();
    $finish;
  end
endmodule